// File: doc/BRIEF.md
# Even/Odd Byte-Bank Access Splitter

This block connects a CPU-side request port to a 16-bit memory that is built from two byte-wide banks. One bank holds the bytes at even byte addresses and the other holds the bytes at odd byte addresses. Each CPU request is a read or a write of either one byte or one 16-bit word at a byte address. Address bit 0 selects the bank. The remaining address bits form the row address that both banks share. The block drives the two bank enables, places write bytes on the correct lane, and brings read bytes back into CPU order.

An aligned word takes one memory cycle with both banks enabled. The low-order byte is on the even lane and the high-order byte is on the odd lane. A word at an odd address cannot be served in one row. The block splits it into two cycles on the same request:
- The first cycle goes to the odd bank at the given row and carries the low byte.
- The second cycle goes to the even bank at the next row and carries the high byte.

For a split read, the two halves are joined into one 16-bit result. The CPU-side ready stays low until the second cycle completes.

Both sides use a valid/ready handshake. The CPU keeps its request steady while valid is high. The memory accepts a cycle, and returns read data for it, in the same clock cycle in which it raises ready. The CPU-side ready acts as the completion strobe of the request.

Top module: `byte_bank_splitter`

## Requirements
- R1: While cpu_valid is low, mem_valid, mem_en_even, mem_en_odd and cpu_ready are all low, including directly after reset.
- R2: mem_valid follows cpu_valid. The first memory cycle of every request uses row cpu_addr[ADDR_W-1:1]. Address bit 0 = 0 means the even bank and 1 means the odd bank.
- R3: A byte write enables only the bank chosen by cpu_addr[0]. It places cpu_wdata[7:0] on that bank's lane: mem_wdata[7:0] for even, mem_wdata[15:8] for odd. The other lane is driven with zero. mem_wdata is zero for every read.
- R4: A byte read returns the byte from the selected bank's lane in cpu_rdata[7:0], with cpu_rdata[15:8] zero, in the cycle in which mem_ready completes it.
- R5: An aligned word (cpu_word=1, cpu_addr[0]=0) completes in one memory cycle with both banks enabled. cpu_wdata[7:0] goes to the even lane and cpu_wdata[15:8] goes to the odd lane. A read returns mem_rdata unchanged. cpu_ready equals mem_ready in that cycle.
- R6: The first cycle of a word at an odd address enables only the odd bank. It places cpu_wdata[7:0] on mem_wdata[15:8], and cpu_ready stays low.
- R7: The second cycle of a word at an odd address enables only the even bank at row cpu_addr[ADDR_W-1:1]+1, wrapping at the top row. It places cpu_wdata[15:8] on mem_wdata[7:0].
- R8: A word read at an odd address returns {even-lane byte of the second cycle, odd-lane byte of the first cycle}. cpu_ready is high only in the completing second cycle.
- R9: While mem_ready is low, the memory cycle does not advance. The bank enables and the row hold, and cpu_ready stays low.
- R10: A new request may follow a completed one in the very next cycle, and it starts with its own first cycle. Every request completes with exactly one cpu_ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present, held until cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 2*BYTE_W | Write data; byte requests use the low byte |
| cpu_rdata | output | 2*BYTE_W | Read result, valid with cpu_ready on reads |
| mem_valid | output | 1 | Memory cycle requested |
| mem_ready | input | 1 | Memory accepts the cycle this clock |
| mem_write | output | 1 | Memory cycle is a write |
| mem_en_even | output | 1 | Even bank enable |
| mem_en_odd | output | 1 | Odd bank enable |
| mem_row | output | ADDR_W-1 | Row address shared by both banks |
| mem_wdata | output | 2*BYTE_W | Lane data: even lane low, odd lane high |
| mem_rdata | input | 2*BYTE_W | Lane read data, valid when mem_ready |

## Verification
The bench builds the block with ADDR_W=8 and BYTE_W=8. With these values it can mirror the two 128-row banks in full and check them against a flat byte image. It also reaches address 0xFF, where a split word wraps from the top row to row 0. The byte width equals the width used in the requirements, so the lane positions are checked exactly. A pseudo-random stall pattern on mem_ready lands stalls inside both halves of split accesses.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    localparam int NUM_LANES = 2;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        RD_NONE      = 3'd0,
        RD_PASS      = 3'd1,
        RD_BYTE_EVEN = 3'd2,
        RD_BYTE_ODD  = 3'd3,
        RD_JOIN      = 3'd4
    } rd_mode_e;

    // Per-cycle decision on which lanes take part and how data moves
    typedef struct packed {
        logic     en_even;
        logic     en_odd;
        logic     hi_even;   // even lane carries the high write byte
        logic     hi_odd;    // odd lane carries the high write byte
        logic     next_row;  // second half of a split word
        logic     last;      // this cycle ends the request
        logic     split;     // request needs two cycles
        rd_mode_e rd_mode;
    } lane_plan_t;

endpackage

// File: rtl/bbs_lane_plan.sv
module bbs_lane_plan
    import bbs_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_word,
    input  logic       req_a0,
    input  phase_e     phase,
    output lane_plan_t plan
);

    always_comb begin
        plan         = '0;
        plan.rd_mode = RD_NONE;
        plan.split   = req_word & req_a0;
        if (req_valid) begin
            if (phase == PH_SECOND) begin
                // high byte of a split word: even bank, following row
                plan.en_even  = 1'b1;
                plan.hi_even  = 1'b1;
                plan.next_row = 1'b1;
                plan.last     = 1'b1;
                plan.rd_mode  = RD_JOIN;
            end else if (!req_word) begin
                plan.en_even = ~req_a0;
                plan.en_odd  = req_a0;
                plan.last    = 1'b1;
                plan.rd_mode = req_a0 ? RD_BYTE_ODD : RD_BYTE_EVEN;
            end else if (!req_a0) begin
                plan.en_even = 1'b1;
                plan.en_odd  = 1'b1;
                plan.hi_odd  = 1'b1;
                plan.last    = 1'b1;
                plan.rd_mode = RD_PASS;
            end else begin
                // low byte of a split word: odd bank, own row
                plan.en_odd  = 1'b1;
                plan.rd_mode = RD_NONE;
            end
        end
    end

endmodule

// File: rtl/bbs_write_steer.sv
module bbs_write_steer
    import bbs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                          wr,
    input  logic [NUM_LANES-1:0]          lane_en,
    input  logic [NUM_LANES-1:0]          lane_hi,
    input  logic [NUM_LANES*BYTE_W-1:0]   wdata,
    output logic [NUM_LANES*BYTE_W-1:0]   lane_data
);

    localparam int DATA_W = NUM_LANES * BYTE_W;

    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;

    assign lo_byte = wdata[BYTE_W-1:0];
    assign hi_byte = wdata[DATA_W-1 -: BYTE_W];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_data[g*BYTE_W +: BYTE_W] =
            (wr && lane_en[g]) ? (lane_hi[g] ? hi_byte : lo_byte) : '0;
    end

endmodule

// File: rtl/bbs_read_merge.sv
module bbs_read_merge
    import bbs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  rd_mode_e                       mode,
    input  logic [NUM_LANES*BYTE_W-1:0]    lane_rdata,
    input  logic [BYTE_W-1:0]              held_lo,
    output logic [NUM_LANES*BYTE_W-1:0]    rdata
);

    localparam int DATA_W = NUM_LANES * BYTE_W;

    logic [BYTE_W-1:0] even_lane;
    logic [BYTE_W-1:0] odd_lane;

    assign even_lane = lane_rdata[BYTE_W-1:0];
    assign odd_lane  = lane_rdata[DATA_W-1 -: BYTE_W];

    always_comb begin
        unique case (mode)
            RD_PASS:      rdata = lane_rdata;
            RD_BYTE_EVEN: rdata = {{BYTE_W{1'b0}}, even_lane};
            RD_BYTE_ODD:  rdata = {{BYTE_W{1'b0}}, odd_lane};
            RD_JOIN:      rdata = {even_lane, held_lo};
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/byte_bank_splitter.sv
module byte_bank_splitter
    import bbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_valid,
    output logic                        cpu_ready,
    input  logic                        cpu_write,
    input  logic                        cpu_word,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [NUM_LANES*BYTE_W-1:0] cpu_wdata,
    output logic [NUM_LANES*BYTE_W-1:0] cpu_rdata,
    output logic                        mem_valid,
    input  logic                        mem_ready,
    output logic                        mem_write,
    output logic                        mem_en_even,
    output logic                        mem_en_odd,
    output logic [ADDR_W-2:0]           mem_row,
    output logic [NUM_LANES*BYTE_W-1:0] mem_wdata,
    input  logic [NUM_LANES*BYTE_W-1:0] mem_rdata
);

    localparam int DATA_W = NUM_LANES * BYTE_W;
    localparam int ROW_W  = ADDR_W - 1;

    typedef struct packed {
        phase_e             phase;
        logic [BYTE_W-1:0]  lo;     // odd-lane byte from the first half
    } state_t;

    state_t     st_d;
    state_t     st_q;
    lane_plan_t plan;

    bbs_lane_plan u_plan (
        .req_valid (cpu_valid),
        .req_word  (cpu_word),
        .req_a0    (cpu_addr[0]),
        .phase     (st_q.phase),
        .plan      (plan)
    );

    bbs_write_steer #(.BYTE_W(BYTE_W)) u_wsteer (
        .wr        (cpu_write),
        .lane_en   ({plan.en_odd, plan.en_even}),
        .lane_hi   ({plan.hi_odd, plan.hi_even}),
        .wdata     (cpu_wdata),
        .lane_data (mem_wdata)
    );

    bbs_read_merge #(.BYTE_W(BYTE_W)) u_rmerge (
        .mode       (plan.rd_mode),
        .lane_rdata (mem_rdata),
        .held_lo    (st_q.lo),
        .rdata      (cpu_rdata)
    );

    assign mem_valid   = cpu_valid;
    assign mem_write   = cpu_write;
    assign mem_en_even = plan.en_even;
    assign mem_en_odd  = plan.en_odd;
    assign mem_row     = cpu_addr[ADDR_W-1:1] + ROW_W'(plan.next_row);
    assign cpu_ready   = mem_ready & plan.last;

    always_comb begin
        st_d = st_q;
        if (cpu_valid && mem_ready) begin
            if (st_q.phase == PH_FIRST && plan.split) begin
                st_d.phase = PH_SECOND;
                st_d.lo    = mem_rdata[DATA_W-1 -: BYTE_W];
            end else if (st_q.phase == PH_SECOND) begin
                st_d.phase = PH_FIRST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_FIRST;
            st_q.lo    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

module bbs_checker #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              cpu_word,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_en_even,
    input logic              mem_en_odd,
    input logic [ADDR_W-2:0] mem_row
);

    localparam int ROW_W = ADDR_W - 1;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> (!mem_valid && !mem_en_even && !mem_en_odd && !cpu_ready)); // R1

    AST_BYTE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_word) |->
            ($countones({mem_en_even, mem_en_odd}) == 1 && mem_en_odd == cpu_addr[0]
             && mem_row == cpu_addr[ADDR_W-1:1])); // R2

    AST_ALIGNED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_word && !cpu_addr[0]) |->
            (mem_en_even && mem_en_odd && cpu_ready == mem_ready)); // R5

    AST_SPLIT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_word && cpu_addr[0] && mem_en_odd) |->
            (!cpu_ready && !mem_en_even)); // R6

    AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_word && cpu_addr[0] && mem_en_odd && mem_ready) |=>
            (!cpu_valid || (mem_en_even && !mem_en_odd
                            && mem_row == ROW_W'($past(mem_row) + 1'b1)))); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !mem_ready) |=>
            (!cpu_valid || $stable({mem_en_even, mem_en_odd, mem_row}))); // R9

    AST_READY_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (mem_ready && cpu_valid)); // R9

endmodule

bind byte_bank_splitter bbs_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_valid   (cpu_valid),
    .cpu_ready   (cpu_ready),
    .cpu_word    (cpu_word),
    .cpu_addr    (cpu_addr),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_en_even (mem_en_even),
    .mem_en_odd  (mem_en_odd),
    .mem_row     (mem_row)
);

// File: tb/byte_bank_splitter_tb.sv
module byte_bank_splitter_tb;

    localparam int AW    = 8;
    localparam int BW    = 8;
    localparam int NROW  = 128;
    localparam int NBYTE = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid, cpu_ready, cpu_write, cpu_word;
    logic [7:0]  cpu_addr;
    logic [15:0] cpu_wdata, cpu_rdata;
    logic        mem_valid, mem_ready, mem_write, mem_en_even, mem_en_odd;
    logic [6:0]  mem_row;
    logic [15:0] mem_wdata, mem_rdata;

    always #2 clk = ~clk;   // 250 MHz

    byte_bank_splitter #(.ADDR_W(AW), .BYTE_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
        .cpu_word(cpu_word), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_en_even(mem_en_even), .mem_en_odd(mem_en_odd), .mem_row(mem_row),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bank model
    logic [7:0] ev_bank [NROW];
    logic [7:0] od_bank [NROW];
    logic [7:0] ref_mem [NBYTE];

    function automatic logic [7:0] seed_byte(input int a);
        return 8'(a * 7 + 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NROW; r++) begin
                ev_bank[r] <= seed_byte(2 * r);
                od_bank[r] <= seed_byte(2 * r + 1);
            end
        end else if (mem_valid && mem_ready && mem_write) begin
            if (mem_en_even) ev_bank[mem_row] <= mem_wdata[7:0];
            if (mem_en_odd)  od_bank[mem_row] <= mem_wdata[15:8];
        end
    end

    always_comb mem_rdata = {od_bank[mem_row], ev_bank[mem_row]};

    // Scoreboard
    typedef struct {
        logic        is_rd;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Monitor: pops one item per completed request
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n === 1'b1 && cpu_valid && cpu_ready) begin
                if (sb_q.size() == 0) begin
                    chk("R10", "unexpected completion", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (it.is_rd) chk(it.tag, "rdata", 32'(cpu_rdata), 32'(it.exp));
                end
            end
        end
    end

    // Stall pattern
    logic [7:0] lfsr = 8'hA7;
    bit         stall_on = 1'b0;

    task automatic next_ready();
        lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = !stall_on || lfsr[0];
    endtask

    // Driver: entered at a falling edge, returns at a falling edge
    task automatic access(input logic wr, input logic wd, input logic [7:0] a,
                          input logic [15:0] d, input string tag);
        item_t      it;
        logic [7:0] a1;
        logic       al, split, second, e_ev, e_od, done;
        logic [6:0] e_row;
        logic [7:0] e_lo, e_hi;
        int         ph, nph, guard;
        a1       = a + 8'd1;
        it.is_rd = !wr;
        it.tag   = tag;
        it.exp   = wd ? {ref_mem[a1], ref_mem[a]} : {8'h00, ref_mem[a]};
        sb_q.push_back(it);
        if (wr) begin
            ref_mem[a] = d[7:0];
            if (wd) ref_mem[a1] = d[15:8];
        end
        al    = wd && !a[0];
        split = wd && a[0];
        nph   = split ? 2 : 1;
        ph    = 0;
        guard = 0;
        cpu_valid = 1'b1; cpu_write = wr; cpu_word = wd;
        cpu_addr  = a;    cpu_wdata = d;
        next_ready();
        forever begin
            #1;
            second = (ph == 1);
            e_ev   = second ? 1'b1 : !a[0];
            e_od   = second ? 1'b0 : (a[0] || al);
            e_row  = a[7:1] + 7'(second);
            e_lo   = (wr && e_ev) ? (second ? d[15:8] : d[7:0]) : 8'h00;
            e_hi   = (wr && e_od) ? (al ? d[15:8] : d[7:0]) : 8'h00;
            chk(tag, "mem_valid",   32'(mem_valid),   32'd1);
            chk(tag, "mem_write",   32'(mem_write),   32'(wr));
            chk(tag, "mem_en_even", 32'(mem_en_even), 32'(e_ev));
            chk(tag, "mem_en_odd",  32'(mem_en_odd),  32'(e_od));
            chk(tag, "mem_row",     32'(mem_row),     32'(e_row));
            chk(tag, "mem_wdata",   32'(mem_wdata),   32'({e_hi, e_lo}));
            done = mem_ready && (ph == nph - 1);
            chk(tag, "cpu_ready",   32'(cpu_ready),   32'(done));
            if (mem_ready) ph++;
            @(negedge clk);
            if (done) break;
            guard++;
            if (guard > 500) begin
                chk(tag, "access timeout", 32'd1, 32'd0);
                break;
            end
            next_ready();
        end
    endtask

    task automatic idle(input string tag);
        cpu_valid = 1'b0;
        mem_ready = 1'b1;
        #1;
        chk(tag, "idle mem_valid", 32'(mem_valid), 32'd0);
        chk(tag, "idle enables",   32'({mem_en_even, mem_en_odd}), 32'd0);
        chk(tag, "idle cpu_ready", 32'(cpu_ready), 32'd0);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog act=%0d exp=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NBYTE; i++) ref_mem[i] = seed_byte(i);
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0; cpu_word = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset mem_valid", 32'(mem_valid), 32'd0);
        chk("R1", "reset enables",   32'({mem_en_even, mem_en_odd}), 32'd0);
        chk("R1", "reset cpu_ready", 32'(cpu_ready), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R1");

        // byte traffic on both banks
        access(1'b1, 1'b0, 8'h20, 16'h77A5, "R3");
        access(1'b1, 1'b0, 8'h21, 16'h665A, "R3");
        idle("R1");
        access(1'b0, 1'b0, 8'h20, 16'h0000, "R4");
        access(1'b0, 1'b0, 8'h21, 16'h0000, "R4");
        access(1'b0, 1'b0, 8'h40, 16'h0000, "R2");
        access(1'b0, 1'b0, 8'h41, 16'h0000, "R2");

        // aligned word
        access(1'b1, 1'b1, 8'h30, 16'hBEEF, "R5");
        access(1'b0, 1'b1, 8'h30, 16'h0000, "R5");
        access(1'b0, 1'b0, 8'h31, 16'h0000, "R5");

        // split word
        access(1'b1, 1'b1, 8'h13, 16'h1234, "R6");
        access(1'b0, 1'b0, 8'h13, 16'h0000, "R6");
        access(1'b0, 1'b0, 8'h14, 16'h0000, "R7");
        access(1'b0, 1'b1, 8'h13, 16'h0000, "R8");
        access(1'b0, 1'b1, 8'h14, 16'h0000, "R8");

        // split word across the top row
        access(1'b1, 1'b1, 8'hFF, 16'hCAFE, "R7");
        access(1'b0, 1'b0, 8'h00, 16'h0000, "R7");
        access(1'b0, 1'b1, 8'hFF, 16'h0000, "R8");
        idle("R1");

        // memory stalls
        stall_on = 1'b1;
        access(1'b0, 1'b1, 8'h13, 16'h0000, "R9");
        access(1'b1, 1'b1, 8'h55, 16'h7788, "R9");
        access(1'b0, 1'b1, 8'h55, 16'h0000, "R9");
        access(1'b0, 1'b1, 8'h56, 16'h0000, "R9");
        access(1'b1, 1'b0, 8'h61, 16'h00C3, "R9");
        access(1'b0, 1'b1, 8'h60, 16'h0000, "R9");

        // back-to-back mixed traffic
        for (int i = 0; i < 60; i++) begin
            stall_on = (i % 4) >= 2;
            access(logic'(i % 2 == 0), logic'(i % 3 != 0), 8'(i * 37 + 5),
                   16'(i * 16'h1357 + 16'h2468), "R10");
        end
        stall_on = 1'b0;
        idle("R1");
        chk("R10", "pending items", 32'(sb_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule